// File: doc/BRIEF.md
# Prescaled Two-Mode Real-Time Counter

This block is the counting core of a real-time clock. A free-running divider on the system clock produces a one-cycle count tick every 2^P cycles, where P is a small prescaler selection. The tick advances a counter that works in one of two modes.

In the wide mode the counter is a full 32-bit up-counter. It has one compare value and can optionally restart from zero after a compare match. In the narrow mode the counter is 16 bits wide, restarts after a programmable period value, and has two compare values. Overflow and compare events set sticky flags. Software clears a flag by writing a one to its bit.

A plain single-cycle register interface gives access to the control fields, the count, the period, the compare values and the flags. A write is taken at the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. The register interface has no back-pressure: every write is accepted in its cycle and every read is valid in the same cycle. The flags are also driven out directly on `irq_flags`.

Top module: `rtc_cnt_core`

## Requirements
- R1: The count tick recurs every 2^P system clock cycles, where P is the prescaler field (CTRL bits [11:8]). With P=0 there is a tick on every cycle.
- R2: The mode field (CTRL bits [3:2]) selects the 32-bit mode with value 0 and the 16-bit period mode with value 1. Values 2 and 3 leave the counter holding its value.
- R3: While enabled (CTRL bit 0), the count advances by one on each tick. While disabled, it holds its value.
- R4: In 32-bit mode, a tick at count 0xFFFFFFFF gives 0x00000000 and sets the overflow flag (FLAGS bit 0).
- R5: Compare flag 0 (FLAGS bit 1) is set at the tick on which the count, before it advances, equals the compare-0 register (address 3). Any count value that is passed over therefore sets the flag.
- R6: In 32-bit mode with clear-on-match set (CTRL bit 4), the tick that sees a compare-0 match loads zero. That same tick sets both the overflow flag and compare flag 0.
- R7: In 16-bit mode, a tick at a count equal to the period register (address 2) gives zero and sets the overflow flag. Otherwise the count advances by one.
- R8: In 16-bit mode, compare-0 and compare-1 (address 4) are both checked against the low 16 count bits. Compare-1 sets flag bit 2.
- R9: In 16-bit mode, the upper 16 bits of the COUNT read (address 1) are zero.
- R10: Writing FLAGS (address 5) clears each flag whose bit is written as one and leaves the other flags unchanged. If a flag is set by the hardware in the same cycle, the set wins.
- R11: Writing CTRL with the software-reset bit (bit 1) while disabled returns every register to zero. While enabled, that write is ignored in full.
- R12: A CTRL write made while enabled leaves the mode field unchanged.
- R13: Writing COUNT (address 0x1) loads the written value at that edge. This load takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 CTRL, 1 COUNT, 2 PERIOD, 3 CMP0, 4 CMP1, 5 FLAGS |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 32 | Combinational read data |
| irq_flags | output | 3 | Flags: bit 0 overflow, bit 1 compare 0, bit 2 compare 1 |

## Verification
A register write takes effect at the clock edge that captures it. A write to CTRL that sets enable first advances the count at the following edge. The new count and any flag it causes are visible right after the edge of the tick itself. The bench drives inputs at the falling edge and reads back half a cycle after each rising edge. It keeps a step-by-step arithmetic model that advances once per rising edge, so each comparison is made exactly one edge after the tick that caused the change. For prescaled runs, the bench measures the spacing between count changes rather than their absolute phase.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_PER   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;

  localparam int CB_EN    = 0;
  localparam int CB_SRST  = 1;
  localparam int CB_MODE  = 2;
  localparam int CB_MCLR  = 4;
  localparam int CB_PSEL  = 8;

  localparam int NFLAG  = 3;
  localparam int FL_OVF = 0;
  localparam int FL_C0  = 1;
  localparam int FL_C1  = 2;

  typedef enum logic [1:0] {
    MODE_WIDE   = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_IDLE2  = 2'd2,
    MODE_IDLE3  = 2'd3
  } mode_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(sel));
    end
  end

  assign tick = ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (soft_clr) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  // R1: with a nonzero selection, two ticks never come back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0 && !soft_clr) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/rtc_count_engine.sv
module rtc_count_engine
  import rtc_pkg::*;
#(
  parameter int W  = 32,
  parameter int NW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             tick_i,
  input  logic             en_i,
  input  mode_e            mode_i,
  input  logic             match_clr_i,
  input  logic [NW-1:0]    per_i,
  input  logic [W-1:0]     cmp0_i,
  input  logic [NW-1:0]    cmp1_i,
  input  logic             load_i,
  input  logic [W-1:0]     load_val_i,
  input  logic [NFLAG-1:0] flag_clr_i,
  output logic [W-1:0]     count_o,
  output logic [NFLAG-1:0] flags_o
);
  localparam int UW = W - NW;

  logic [W-1:0]     count_q, cnt_nx;
  logic [NFLAG-1:0] flags_q, set;
  logic             wide, narrow, step, hit0, hit1;

  assign wide   = (mode_i == MODE_WIDE);
  assign narrow = (mode_i == MODE_NARROW);
  assign step   = tick_i && en_i;

  always_comb begin
    hit0 = wide ? (count_q == cmp0_i) : (count_q[NW-1:0] == cmp0_i[NW-1:0]);
    hit1 = narrow && (count_q[NW-1:0] == cmp1_i);
  end

  always_comb begin
    set    = '0;
    cnt_nx = count_q;
    if (step && wide) begin
      set[FL_C0] = hit0;
      if (match_clr_i && hit0) begin
        cnt_nx      = '0;
        set[FL_OVF] = 1'b1;
      end else if (&count_q) begin
        cnt_nx      = '0;
        set[FL_OVF] = 1'b1;
      end else begin
        cnt_nx = count_q + 1'b1;
      end
    end else if (step && narrow) begin
      set[FL_C0] = hit0;
      set[FL_C1] = hit1;
      if (count_q[NW-1:0] == per_i) begin
        cnt_nx      = '0;
        set[FL_OVF] = 1'b1;
      end else begin
        cnt_nx = {{UW{1'b0}}, count_q[NW-1:0] + 1'b1};
      end
    end
    if (load_i) begin
      cnt_nx = narrow ? {{UW{1'b0}}, load_val_i[NW-1:0]} : load_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      flags_q <= '0;
    end else if (soft_clr) begin
      count_q <= '0;
      flags_q <= '0;
    end else begin
      count_q <= cnt_nx;
      flags_q <= (flags_q & ~flag_clr_i) | set;
    end
  end

  assign count_o = count_q;
  assign flags_o = flags_q;

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_i && !soft_clr) |=> $stable(count_q));
  assert_wide_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wide && !load_i && !soft_clr && (&count_q)) |=> (count_q == '0 && flags_q[FL_OVF]));
  assert_cmp0_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wide && !soft_clr && count_q == cmp0_i) |=> flags_q[FL_C0]);
  assert_match_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wide && match_clr_i && hit0 && !load_i && !soft_clr)
      |=> (count_q == '0 && flags_q[FL_OVF] && flags_q[FL_C0]));
  assert_period_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && narrow && !load_i && !soft_clr && count_q[NW-1:0] == per_i)
      |=> (count_q == '0 && flags_q[FL_OVF]));
  assert_cmp1_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && narrow && !soft_clr && count_q[NW-1:0] == cmp1_i) |=> flags_q[FL_C1]);
  assert_idle_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !narrow && !load_i && !soft_clr) |=> $stable(count_q));
endmodule

// File: rtl/rtc_cnt_core.sv
module rtc_cnt_core
  import rtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16,
  parameter int PSEL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [CNT_W-1:0]     rd_data,
  output logic [NFLAG-1:0]     irq_flags
);
  logic              en_q, mclr_q;
  mode_e             mode_q;
  logic [PSEL_W-1:0] psel_q;
  logic [HALF_W-1:0] per_q, cmp1_q;
  logic [CNT_W-1:0]  cmp0_q, count;
  logic              tick, soft_clr, ctrl_wr, load;
  logic [NFLAG-1:0]  flag_clr;

  assign ctrl_wr  = wr_en && wr_addr == A_CTRL;
  assign soft_clr = ctrl_wr && wr_data[CB_SRST] && !en_q;
  assign load     = wr_en && wr_addr == A_COUNT;
  assign flag_clr = (wr_en && wr_addr == A_FLAGS) ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mclr_q <= 1'b0;
      mode_q <= MODE_WIDE;
      psel_q <= '0;
      per_q  <= '0;
      cmp0_q <= '0;
      cmp1_q <= '0;
    end else if (soft_clr) begin
      en_q   <= 1'b0;
      mclr_q <= 1'b0;
      mode_q <= MODE_WIDE;
      psel_q <= '0;
      per_q  <= '0;
      cmp0_q <= '0;
      cmp1_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          if (!wr_data[CB_SRST]) begin
            en_q   <= wr_data[CB_EN];
            mclr_q <= wr_data[CB_MCLR];
            psel_q <= wr_data[CB_PSEL +: PSEL_W];
            if (!en_q) mode_q <= mode_e'(wr_data[CB_MODE +: 2]);
          end
        end
        A_PER:  per_q  <= wr_data[HALF_W-1:0];
        A_CMP0: cmp0_q <= wr_data;
        A_CMP1: cmp1_q <= wr_data[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  rtc_prescaler #(.SEL_W(PSEL_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .sel      (psel_q),
    .tick     (tick)
  );

  rtc_count_engine #(.W(CNT_W), .NW(HALF_W)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_clr    (soft_clr),
    .tick_i      (tick),
    .en_i        (en_q),
    .mode_i      (mode_q),
    .match_clr_i (mclr_q),
    .per_i       (per_q),
    .cmp0_i      (cmp0_q),
    .cmp1_i      (cmp1_q),
    .load_i      (load),
    .load_val_i  (wr_data),
    .flag_clr_i  (flag_clr),
    .count_o     (count),
    .flags_o     (irq_flags)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[CB_EN]             = en_q;
        rd_data[CB_MODE +: 2]      = mode_q;
        rd_data[CB_MCLR]           = mclr_q;
        rd_data[CB_PSEL +: PSEL_W] = psel_q;
      end
      A_COUNT: rd_data = (mode_q == MODE_NARROW)
                         ? {{(CNT_W-HALF_W){1'b0}}, count[HALF_W-1:0]} : count;
      A_PER:   rd_data[HALF_W-1:0] = per_q;
      A_CMP0:  rd_data = cmp0_q;
      A_CMP1:  rd_data[HALF_W-1:0] = cmp1_q;
      A_FLAGS: rd_data[NFLAG-1:0] = irq_flags;
      default: rd_data = '0;
    endcase
  end

  assert_srst_ignored_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[CB_SRST] && en_q) |=> en_q);
  assert_mode_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && en_q) |=> $stable(mode_q));
  assert_load_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode_q == MODE_WIDE) |=> (count == $past(wr_data)));
endmodule

// File: tb/test_rtc_cnt_core.sv
module test_rtc_cnt_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  irq_flags;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtc_cnt_core i_rtc_cnt_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_flags(irq_flags)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [31:0] ctl(input bit en, input int mode, input bit mclr, input int psel);
    return {20'd0, 4'(psel), 3'd0, mclr, 2'(mode), 1'b0, en};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, c, fl, prev;
    int last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd(3'd0, v); chk("reset CTRL R11", v, 0);
    rd(3'd1, v); chk("reset COUNT R3", v, 0);
    chk("reset flags R10", {29'd0, irq_flags}, 0);

    // R13 load then R3 advance, P=0
    wr(3'd1, 32'd100);
    wr(3'd0, ctl(1, 0, 0, 0));
    rd(3'd1, v); chk("R3 enable edge holds", v, 100);
    @(negedge clk); rd(3'd1, v); chk("R3 advance one", v, 101);
    @(negedge clk); rd(3'd1, v); chk("R3 advance two", v, 102);
    wr(3'd1, 32'd500);
    rd(3'd1, v); chk("R13 load beats tick", v, 500);
    @(negedge clk); rd(3'd1, v); chk("R13 counts from load", v, 501);

    // R12 mode locked while enabled; R11 srst ignored while enabled
    wr(3'd0, ctl(1, 1, 0, 0));
    rd(3'd0, v); chk("R12 mode unchanged", v[3:2], 0);
    wr(3'd0, ctl(1, 0, 0, 0) | 32'h2);
    rd(3'd0, v); chk("R11 srst ignored enabled", v[0], 1);

    // R3 hold when disabled
    wr(3'd0, ctl(0, 0, 0, 0));
    rd(3'd1, prev);
    repeat (5) @(negedge clk);
    rd(3'd1, v); chk("R3 hold disabled", v, prev);

    // R4 wide wrap
    wr(3'd5, 32'h7);
    wr(3'd3, 32'h1000);
    wr(3'd1, 32'hFFFFFFFD);
    wr(3'd0, ctl(1, 0, 0, 0));
    @(negedge clk); rd(3'd1, v); chk("R4 FFFFFFFE", v, 32'hFFFFFFFE);
    chk("R4 no ovf early", irq_flags[0], 0);
    @(negedge clk); rd(3'd1, v); chk("R4 FFFFFFFF", v, 32'hFFFFFFFF);
    @(negedge clk); rd(3'd1, v); chk("R4 wrap zero", v, 0);
    chk("R4 ovf set", irq_flags[0], 1);
    wr(3'd0, ctl(0, 0, 0, 0));

    // R10 partial W1C
    wr(3'd1, 32'd3); wr(3'd3, 32'd4);
    wr(3'd0, ctl(1, 0, 0, 0));
    repeat (3) @(negedge clk);
    wr(3'd0, ctl(0, 0, 0, 0));
    chk("R5 cmp0 flag set", irq_flags, 3'b011);
    wr(3'd5, 32'h2);
    chk("R10 clear only cmp0", irq_flags, 3'b001);
    wr(3'd5, 32'h7);
    chk("R10 clear all", irq_flags, 0);

    // R5/R6 wide sweep over compare value and clear-on-match
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 5; k++) begin
        wr(3'd0, ctl(0, 0, m[0], 0));
        wr(3'd1, 0); wr(3'd3, k); wr(3'd5, 7);
        c = 0; fl = 0;
        wr(3'd0, ctl(1, 0, m[0], 0));
        for (int t = 0; t < 12; t++) begin
          @(negedge clk);
          if (c == k) fl[1] = 1;
          if (m == 1 && c == k) begin c = 0; fl[0] = 1; end
          else c = c + 1;
          rd(3'd1, v);
          chk(m == 1 ? "R6 count" : "R5 count", v, c);
          chk(m == 1 ? "R6 flags" : "R5 flags", {29'd0, irq_flags}, fl);
        end
        wr(3'd0, ctl(0, 0, m[0], 0));
      end
    end

    // R7/R8 narrow sweep over period and compare values
    for (int p = 1; p <= 5; p++) begin
      for (int k = 0; k <= p; k++) begin
        wr(3'd0, ctl(0, 1, 0, 0));
        wr(3'd1, 0); wr(3'd2, p); wr(3'd3, k); wr(3'd4, p - k); wr(3'd5, 7);
        c = 0; fl = 0;
        wr(3'd0, ctl(1, 1, 0, 0));
        for (int t = 0; t < 2 * p + 4; t++) begin
          @(negedge clk);
          if (c == k) fl[1] = 1;
          if (c == p - k) fl[2] = 1;
          if (c == p) begin c = 0; fl[0] = 1; end
          else c = c + 1;
          rd(3'd1, v); chk("R7 count", v, c);
          chk("R8 flags", {29'd0, irq_flags}, fl);
        end
        wr(3'd0, ctl(0, 1, 0, 0));
      end
    end

    // R9 upper bits zero in narrow mode
    wr(3'd0, ctl(0, 0, 0, 0));
    wr(3'd1, 32'h12345678);
    wr(3'd0, ctl(0, 1, 0, 0));
    rd(3'd1, v); chk("R9 upper zero", v, 32'h5678);

    // R2 idle mode holds
    wr(3'd0, ctl(0, 2, 0, 0));
    wr(3'd1, 32'd77);
    wr(3'd0, ctl(1, 2, 0, 0));
    repeat (4) @(negedge clk);
    rd(3'd1, v); chk("R2 idle mode holds", v, 77);
    wr(3'd0, ctl(0, 2, 0, 0));

    // R1 prescaler P=2: changes every 4 cycles
    wr(3'd0, ctl(0, 0, 0, 2));
    wr(3'd1, 0); wr(3'd3, 32'hFFFF0000);
    wr(3'd0, ctl(1, 0, 0, 2));
    rd(3'd1, prev); last = -1;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      rd(3'd1, v);
      if (v != prev) begin
        chk("R1 step by one", v, prev + 1);
        if (last >= 0) chk("R1 tick spacing", t - last, 4);
        last = t; prev = v;
      end
    end
    chk("R1 tick total", prev, 10);

    // R11 software reset while disabled
    wr(3'd0, ctl(0, 1, 0, 0));
    wr(3'd2, 9);
    wr(3'd0, 32'h2);
    rd(3'd0, v); chk("R11 ctrl cleared", v, 0);
    rd(3'd1, v); chk("R11 count cleared", v, 0);
    rd(3'd2, v); chk("R11 period cleared", v, 0);
    rd(3'd3, v); chk("R11 cmp0 cleared", v, 0);
    chk("R11 flags cleared", {29'd0, irq_flags}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule